// File: doc/BRIEF.md
# Inbound Memory Window Hold Controller

This block sits on the target side of a host bridge and decides whether a PCI address seen by the bridge belongs to local main memory. Every offered address is compared against a programmable base and mask. On a match, the block asks the CPU to give up its memory bus through an active-low hold request. It waits for the active-low hold acknowledge, and only then enables the bridge's SDRAM control drivers and starts an 8-beat burst in an SDRAM sequencer.

When the burst ends, the block drops the drive enable one cycle before it releases the hold request. It then enforces a programmable quiet interval before it accepts the next address. The interval is set in units of 30 ns. One unit equals `UNIT_CYCLES` clock cycles, so with the default of 3 cycles the block clock is 100 MHz.

The address input is a valid/ready stream. `rq_ready_o` is high only while the block is idle and the quiet interval has run out. A requester that sees ready low must keep `rq_valid_i` and `rq_addr_i` stable until a cycle in which both valid and ready are high. A missing address is accepted in one cycle and dropped.

Top module: `inb_win_hold_top`

## Requirements
- R1: An accepted address hits when `(addr & ~win_mask_i) == (win_base_i & ~win_mask_i)`. `hit_o` is high for exactly the one cycle after the accepting clock edge.
- R2: An accepted address that misses leaves `hit_o` low and leaves `hold_req_no` high. `rq_ready_o` is high again in the very next cycle.
- R3: After an accepted hit, `hold_req_no` goes low in the next cycle. `drv_en_o` stays low for as long as `hold_ack_ni` is sampled high.
- R4: In the cycle after `hold_ack_ni` is first sampled low while a request is pending, `drv_en_o` rises and `burst_start_o` pulses for one cycle. At that point `burst_addr_o` equals the accepted address.
- R5: `drv_en_o` stays high for exactly BURST_LEN cycles. The default is 8, one cycle per data beat.
- R6: `hold_req_no` returns high exactly one cycle after `drv_en_o` falls.
- R7: `rq_ready_o` is low from an accepted hit until the hold request is released. It then stays low for a further `gap_units_i * UNIT_CYCLES` cycles, using the value of `gap_units_i` at the release. A value of 0 makes the block ready in the same cycle the hold is released.
- R8: `hold_ack_ni` low while no request is pending has no effect: `drv_en_o` and `burst_start_o` stay low and `hold_req_no` stays high.
- R9: After reset, `hold_req_no` is 1, `drv_en_o`, `burst_start_o` and `hit_o` are 0, and `rq_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_base_i | input | ADDR_W | Window base address |
| win_mask_i | input | ADDR_W | Window size mask; ones mark ignored address bits |
| gap_units_i | input | LAT_W | Quiet interval between accesses, in 30 ns units |
| rq_valid_i | input | 1 | Address offer valid |
| rq_ready_o | output | 1 | Block can accept an address |
| rq_addr_i | input | ADDR_W | Offered PCI target address |
| hold_ack_ni | input | 1 | CPU bus hold acknowledge, active low |
| hit_o | output | 1 | One-cycle pulse: accepted address fell in the window |
| hold_req_no | output | 1 | CPU bus hold request, active low |
| drv_en_o | output | 1 | Enable for SDRAM control drivers |
| burst_start_o | output | 1 | One-cycle burst start to the SDRAM sequencer |
| burst_addr_o | output | ADDR_W | Address of the burst |

## Verification
Each fault in the control state shows at the ports within one burst length. A sequencer stuck in the wrong phase either enables the drivers without a prior acknowledge, or keeps the bus held after the drivers drop. The bench sees either case in the cycle it happens.

A wrong beat count shows as a drive-enable pulse that is not exactly eight cycles wide. A mis-loaded or mis-counting gap timer shows as ready returning too early or too late. The bench measures that interval to the cycle after every burst.

Comparator faults show in the cycle after acceptance, as a wrong `hit_o` or a missing fall of the hold request. The bench probes those faults at both edges of the window.

// File: rtl/inb_win_hold_pkg.sv
package inb_win_hold_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_ACK = 2'd1,
    ST_BURST    = 2'd2,
    ST_RELEASE  = 2'd3
  } hold_state_e;
endpackage

// File: rtl/inb_win_match.sv
module inb_win_match #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] mask_i,
  output logic              hit_o
);
  logic [ADDR_W-1:0] diff;

  // Bits set in the mask are don't-care; all others must agree.
  assign diff  = (addr_i ^ base_i) & ~mask_i;
  assign hit_o = (diff == '0);
endmodule

// File: rtl/inb_gap_timer.sv
module inb_gap_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (cnt_q != '0);

  // R7: the quiet interval shrinks by exactly one each cycle.
  a_r7_gap_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/inb_hold_seq.sv
module inb_hold_seq
  import inb_win_hold_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BURST_LEN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              hit_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ack_ni,
  output logic              idle_o,
  output logic              release_o,
  output logic              hit_o,
  output logic              hold_req_no,
  output logic              drv_en_o,
  output logic              burst_start_o,
  output logic [ADDR_W-1:0] burst_addr_o
);
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

  hold_state_e       state_q;
  logic [BEAT_W-1:0] beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      beat_q        <= '0;
      hit_o         <= 1'b0;
      hold_req_no   <= 1'b1;
      drv_en_o      <= 1'b0;
      burst_start_o <= 1'b0;
      burst_addr_o  <= '0;
    end else begin
      hit_o         <= 1'b0;
      burst_start_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept_i) begin
            hit_o <= hit_i;
            if (hit_i) begin
              state_q      <= ST_WAIT_ACK;
              hold_req_no  <= 1'b0;
              burst_addr_o <= addr_i;
            end
          end
        end
        ST_WAIT_ACK: begin
          if (!ack_ni) begin
            state_q       <= ST_BURST;
            drv_en_o      <= 1'b1;
            burst_start_o <= 1'b1;
            beat_q        <= '0;
          end
        end
        ST_BURST: begin
          if (beat_q == LAST_BEAT) begin
            drv_en_o <= 1'b0;
            state_q  <= ST_RELEASE;
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
        ST_RELEASE: begin
          hold_req_no <= 1'b1;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o    = (state_q == ST_IDLE);
  assign release_o = (state_q == ST_RELEASE);

  // R3: a hold request only follows an accepted hit.
  a_r3_req_after_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_req_no) |-> $past(accept_i && hit_i));
  // R3: drivers never enable without the bus being held.
  a_r3_drive_under_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_en_o |-> !hold_req_no);
  // R4: drivers enable only after an acknowledge was sampled.
  a_r4_ack_before_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv_en_o) |-> $past(!ack_ni));
  // R4: burst start is a single-cycle pulse.
  a_r4_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_start_o |=> !burst_start_o);
  // R6: hold is released the cycle after the drivers drop.
  a_r6_release_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drv_en_o) |=> $rose(hold_req_no));
endmodule

// File: rtl/inb_win_hold_top.sv
module inb_win_hold_top #(
  parameter int ADDR_W      = 32,
  parameter int LAT_W       = 8,
  parameter int UNIT_CYCLES = 3,
  parameter int BURST_LEN   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] win_base_i,
  input  logic [ADDR_W-1:0] win_mask_i,
  input  logic [LAT_W-1:0]  gap_units_i,
  input  logic              rq_valid_i,
  output logic              rq_ready_o,
  input  logic [ADDR_W-1:0] rq_addr_i,
  input  logic              hold_ack_ni,
  output logic              hit_o,
  output logic              hold_req_no,
  output logic              drv_en_o,
  output logic              burst_start_o,
  output logic [ADDR_W-1:0] burst_addr_o
);
  localparam int GAP_MAX = ((1 << LAT_W) - 1) * UNIT_CYCLES;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);

  logic             win_hit;
  logic             seq_idle;
  logic             seq_release;
  logic             gap_busy;
  logic             accept;
  logic [GAP_W-1:0] gap_load;

  assign gap_load = GAP_W'(gap_units_i) * GAP_W'(UNIT_CYCLES);

  inb_win_match #(.ADDR_W(ADDR_W)) u_match (
    .addr_i (rq_addr_i),
    .base_i (win_base_i),
    .mask_i (win_mask_i),
    .hit_o  (win_hit)
  );

  inb_gap_timer #(.CNT_W(GAP_W)) u_gap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (seq_release),
    .load_val_i (gap_load),
    .busy_o     (gap_busy)
  );

  inb_hold_seq #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .accept_i      (accept),
    .hit_i         (win_hit),
    .addr_i        (rq_addr_i),
    .ack_ni        (hold_ack_ni),
    .idle_o        (seq_idle),
    .release_o     (seq_release),
    .hit_o         (hit_o),
    .hold_req_no   (hold_req_no),
    .drv_en_o      (drv_en_o),
    .burst_start_o (burst_start_o),
    .burst_addr_o  (burst_addr_o)
  );

  assign rq_ready_o = seq_idle && !gap_busy;
  assign accept     = rq_valid_i && rq_ready_o;

  // R7: nothing is accepted while the bus is held.
  a_r7_no_accept_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_req_no |-> !rq_ready_o);
  // R2: a miss never produces a hit pulse or a hold request.
  a_r2_miss_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !win_hit) |=> (!hit_o && hold_req_no));
endmodule

// File: tb/inb_win_hold_top_tb_top.sv
module inb_win_hold_top_tb_top;
  localparam int UNIT = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] win_base, win_mask, rq_addr, burst_addr;
  logic [7:0]  gap_units;
  logic        rq_valid, rq_ready, hold_ack_n;
  logic        hit, hold_req_n, drv_en, burst_start;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  inb_win_hold_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .win_base_i(win_base), .win_mask_i(win_mask),
    .gap_units_i(gap_units), .rq_valid_i(rq_valid), .rq_ready_o(rq_ready),
    .rq_addr_i(rq_addr), .hold_ack_ni(hold_ack_n), .hit_o(hit),
    .hold_req_no(hold_req_n), .drv_en_o(drv_en), .burst_start_o(burst_start),
    .burst_addr_o(burst_addr)
  );

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(hold_req_n == 1'b1, "R9 hold_req", hold_req_n, 1);
    chk(drv_en == 1'b0, "R9 drv_en", drv_en, 0);
    chk(burst_start == 1'b0, "R9 burst_start", burst_start, 0);
    chk(hit == 1'b0, "R9 hit", hit, 0);
    chk(rq_ready == 1'b1, "R9 ready", rq_ready, 1);
  endtask

  task automatic t_hit(input logic [31:0] a, input int units, input int ack_dly);
    int n;
    int g;
    gap_units = 8'(units);
    rq_addr = a;
    rq_valid = 1'b1;
    chk(rq_ready == 1'b1, "R7 ready before", rq_ready, 1);
    @(negedge clk);
    rq_valid = 1'b0;
    chk(hit == 1'b1, "R1 hit pulse", hit, 1);
    chk(hold_req_n == 1'b0, "R3 hold request", hold_req_n, 0);
    chk(rq_ready == 1'b0, "R7 busy ready", rq_ready, 0);
    for (int i = 0; i < ack_dly; i++) begin
      @(negedge clk);
      chk(drv_en == 1'b0, "R3 no drive w/o ack", drv_en, 0);
      if (i == 0) chk(hit == 1'b0, "R1 hit one cycle", hit, 0);
    end
    hold_ack_n = 1'b0;
    @(negedge clk);
    hold_ack_n = 1'b1;
    chk(drv_en == 1'b1, "R4 drive on", drv_en, 1);
    chk(burst_start == 1'b1, "R4 start pulse", burst_start, 1);
    chk(burst_addr == a, "R4 burst addr", burst_addr, a);
    n = 0;
    while (drv_en === 1'b1 && n < 50) begin
      n++;
      @(negedge clk);
      if (n == 1) chk(burst_start == 1'b0, "R4 start one cycle", burst_start, 0);
    end
    chk(n == 8, "R5 drive width", n, 8);
    chk(hold_req_n == 1'b0, "R6 hold still low", hold_req_n, 0);
    @(negedge clk);
    chk(hold_req_n == 1'b1, "R6 hold released", hold_req_n, 1);
    g = 0;
    while (rq_ready !== 1'b1 && g < 2000) begin
      g++;
      @(negedge clk);
    end
    chk(g == units * UNIT, "R7 gap length", g, units * UNIT);
  endtask

  task automatic t_miss(input logic [31:0] a);
    rq_addr = a;
    rq_valid = 1'b1;
    @(negedge clk);
    rq_valid = 1'b0;
    chk(hit == 1'b0, "R2 no hit", hit, 0);
    chk(hold_req_n == 1'b1, "R2 no hold", hold_req_n, 1);
    chk(rq_ready == 1'b1, "R2 ready again", rq_ready, 1);
    @(negedge clk);
    chk(hold_req_n == 1'b1, "R2 still no hold", hold_req_n, 1);
  endtask

  task automatic t_stray_ack();
    hold_ack_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(drv_en == 1'b0, "R8 drive idle", drv_en, 0);
      chk(burst_start == 1'b0, "R8 no start", burst_start, 0);
      chk(hold_req_n == 1'b1, "R8 no hold", hold_req_n, 1);
    end
    hold_ack_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    rq_valid = 1'b0;
    rq_addr = '0;
    hold_ack_n = 1'b1;
    win_base = 32'h0400_0000;
    win_mask = 32'h03FF_FFFF;
    gap_units = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hit(32'h0412_3450, 2, 3);
    t_miss(32'h0800_0000);
    t_hit(32'h07FF_FFFC, 0, 0);
    t_miss(32'h03FF_FFFC);
    t_stray_ack();
    t_hit(32'h0400_0000, 1, 1);
    win_base = 32'h1000_0000;
    win_mask = 32'h0000_0FFF;
    t_miss(32'h1000_1000);
    t_hit(32'h1000_0FF0, 255, 2);
    t_hit(32'h1000_0004, 7, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule